// File: doc/BRIEF.md
# Receive Character Queue with Automatic RTS Throttling

This block buffers received serial characters between a UART receiver and the host register interface of one channel. Each stored entry holds the character together with three status flags: framing error, parity error and break. The host always sees the oldest entry on its read port and removes it with a read strobe. The queue capacity is chosen at run time, either 8 or 16 entries.

The block drives an active-low request-to-send output for the far transmitter. The host sets an output-port bit to allow RTS at all. When automatic throttling is enabled and the queue is full, the start bit of the next character negates RTS. RTS is asserted again as soon as a slot frees up, and the host bit is left untouched throughout. A character that arrives while the queue is full is dropped, and a sticky overrun flag records the loss.

The status flags have two modes. In per-character mode they describe only the entry at the head of the queue. In accumulated mode they hold the OR of the flags of every entry that has reached the head since the last error-clear command.

Top module: `rxq_flow_fifo`

## Requirements
- R1: After reset the queue is empty: `rx_ready`=0, `rx_full`=0, `overrun`=0, all three status flags are 0 and `rd_data` is 0.
- R2: Entries leave in the order they were written. `rd_data` shows the oldest entry's character, and a `rd_en` pulse on a non-empty queue removes it so that the next entry shows in the following cycle.
- R3: With `cfg_deep`=0 the capacity is 8 entries, and with `cfg_deep`=1 it is 16. `rx_full` is 1 exactly when the stored count equals the capacity, and `rx_ready` is 1 when the count is non-zero. `cfg_deep` may change only while the queue is empty.
- R4: A `wr_en` pulse in a cycle where `rx_full` is 1 stores nothing, even if `rd_en` is also high. The queue contents and order stay unchanged, and `overrun` becomes 1 in the next cycle.
- R5: `overrun` stays 1 until an `err_clr` pulse clears it. If a loss and `err_clr` occur in the same cycle, the loss wins.
- R6: With `cfg_block_mode`=0, `st_fe`, `st_pe` and `st_brk` equal the flags of the head entry, and they are 0 while the queue is empty.
- R7: With `cfg_block_mode`=1, each flag is the OR of that flag over every entry that has been at the head since the last `err_clr` pulse, including the current head. `err_clr` discards the accumulated value, and the accumulated value persists after the queue drains.
- R8: If `cfg_rts_en`=1, `host_rts_bit`=1 and `rx_full`=1 when `start_det` pulses, `rts_n` goes to 1 in the next cycle and stays 1 while the queue remains full.
- R9: Once a throttled queue drops below capacity, `rts_n` returns to 0 in the same cycle that `rx_full` falls, with no host action.
- R10: With `cfg_rts_en`=0, `rts_n` equals the inverse of `host_rts_bit` regardless of fill level or `start_det`. With `host_rts_bit`=0, `rts_n` is 1 in all cases.
- R11: A `rd_en` pulse on an empty queue changes nothing: `rx_ready` stays 0 and `rd_data` keeps the character most recently removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver delivers one character this cycle |
| wr_data | input | DATA_W | Received character |
| wr_fe | input | 1 | Framing error of the delivered character |
| wr_pe | input | 1 | Parity error of the delivered character |
| wr_brk | input | 1 | Break seen on the delivered character |
| start_det | input | 1 | Receiver detected a valid start bit |
| rd_en | input | 1 | Host removes the head entry |
| err_clr | input | 1 | Error-clear command |
| cfg_rts_en | input | 1 | Enable automatic RTS throttling |
| cfg_block_mode | input | 1 | 0 per-character flags, 1 accumulated flags |
| cfg_deep | input | 1 | 0 capacity 8, 1 capacity 16 |
| host_rts_bit | input | 1 | Host output-port bit that requests RTS |
| rd_data | output | DATA_W | Head character, or the last removed one when empty |
| st_fe | output | 1 | Framing error status |
| st_pe | output | 1 | Parity error status |
| st_brk | output | 1 | Break status |
| rx_ready | output | 1 | Queue holds at least one entry |
| rx_full | output | 1 | Queue holds its capacity |
| overrun | output | 1 | Sticky character-lost flag |
| rts_n | output | 1 | Active-low request to send |

## Verification
The queue is filled to capacity at both depths with characters and flag patterns that differ from entry to entry. Reading the entries back therefore separates a correct order from a swapped or stale head, and filling to capacity shows whether `rx_full` rises one entry early or late. A start bit is given on a full queue with throttling on and then with it off, which tells whether RTS depends on the enable, the fill level and the host bit. A write to a full queue shows whether the character is dropped or overwrites an entry. In accumulated mode, a sequence of heads that each carry a different flag, followed by a clear taken mid-queue, separates a true OR from head-only reporting and shows whether the clear takes effect.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   // status flag lanes carried beside each character
   localparam int FLAG_N = 3;
   localparam int FL_FRAME  = 0;
   localparam int FL_PARITY = 1;
   localparam int FL_BREAK  = 2;
   typedef logic [FLAG_N-1:0] rxq_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int MAX_DEPTH     = 16,
   parameter int SHALLOW_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              deep,
   input  logic [DATA_W-1:0] in_data,
   input  rxq_flags_t        in_flags,
   output logic [DATA_W-1:0] top_data,
   output rxq_flags_t        top_flags,
   output logic              empty,
   output logic              full,
   output logic              lost
);
   localparam int PTR_W = $clog2(MAX_DEPTH);
   localparam int CNT_W = $clog2(MAX_DEPTH + 1);
   localparam int ENT_W = DATA_W + FLAG_N;

   logic [ENT_W-1:0] mem [MAX_DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt, cap;
   logic [ENT_W-1:0] last_q, head;
   logic             wr_ok, rd_ok;

   // capacity only limits the count; pointers always wrap at MAX_DEPTH
   assign cap   = deep ? CNT_W'(MAX_DEPTH) : CNT_W'(SHALLOW_DEPTH);
   assign full  = (cnt >= cap);
   assign empty = (cnt == '0);
   assign wr_ok = push & ~full;
   assign rd_ok = pop & ~empty;
   assign lost  = push & full;

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= {in_flags, in_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
         last_q <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) begin
            rd_ptr <= rd_ptr + 1'b1;
            last_q <= mem[rd_ptr];
         end
         cnt <= cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
      end
   end

   assign head      = empty ? last_q : mem[rd_ptr];
   assign top_data  = head[DATA_W-1:0];
   assign top_flags = head[ENT_W-1:DATA_W];
endmodule

// File: rtl/rxq_status.sv
module rxq_status
   import rxq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  rxq_flags_t top_flags,
   input  logic       top_valid,
   input  logic       block_mode,
   input  logic       err_clr,
   input  logic       lost,
   output rxq_flags_t st_flags,
   output logic       overrun
);
   rxq_flags_t cur;
   rxq_flags_t acc_q;

   assign cur = top_valid ? top_flags : '0;

   // one accumulator lane per status flag
   for (genvar i = 0; i < FLAG_N; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       acc_q[i] <= 1'b0;
         else if (err_clr) acc_q[i] <= 1'b0;
         else              acc_q[i] <= acc_q[i] | cur[i];
      end
      assign st_flags[i] = block_mode ? (acc_q[i] | cur[i]) : cur[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       overrun <= 1'b0;
      else if (lost)    overrun <= 1'b1;
      else if (err_clr) overrun <= 1'b0;
   end
endmodule

// File: rtl/rxq_rts.sv
module rxq_rts (
   input  logic clk,
   input  logic rst_n,
   input  logic rts_en,
   input  logic host_bit,
   input  logic full,
   input  logic start_det,
   output logic rts_n
);
   logic hold_q;
   logic throttle;

   // negation is armed by a start bit on a full queue, held while full
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= rts_en & full & (hold_q | start_det);
   end

   // release follows the full indication directly
   assign throttle = rts_en & full & hold_q;
   assign rts_n    = ~(host_bit & ~throttle);
endmodule

// File: rtl/rxq_flow_fifo.sv
module rxq_flow_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int MAX_DEPTH     = 16,
   parameter int SHALLOW_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_fe,
   input  logic              wr_pe,
   input  logic              wr_brk,
   input  logic              start_det,
   input  logic              rd_en,
   input  logic              err_clr,
   input  logic              cfg_rts_en,
   input  logic              cfg_block_mode,
   input  logic              cfg_deep,
   input  logic              host_rts_bit,
   output logic [DATA_W-1:0] rd_data,
   output logic              st_fe,
   output logic              st_pe,
   output logic              st_brk,
   output logic              rx_ready,
   output logic              rx_full,
   output logic              overrun,
   output logic              rts_n
);
   if ((MAX_DEPTH < 2) || ((MAX_DEPTH & (MAX_DEPTH - 1)) != 0)) begin : g_bad_max
      $error("MAX_DEPTH must be a power of two of at least 2");
   end
   if ((SHALLOW_DEPTH < 1) || (SHALLOW_DEPTH > MAX_DEPTH)) begin : g_bad_shallow
      $error("SHALLOW_DEPTH must lie in 1..MAX_DEPTH");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   rxq_flags_t in_flags, top_flags, st_flags;
   logic       empty, full, lost;

   assign in_flags[FL_FRAME]  = wr_fe;
   assign in_flags[FL_PARITY] = wr_pe;
   assign in_flags[FL_BREAK]  = wr_brk;

   rxq_store #(
      .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .SHALLOW_DEPTH(SHALLOW_DEPTH)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .push(wr_en), .pop(rd_en), .deep(cfg_deep),
      .in_data(wr_data), .in_flags(in_flags), .top_data(rd_data),
      .top_flags(top_flags), .empty(empty), .full(full), .lost(lost)
   );

   rxq_status i_status (
      .clk(clk), .rst_n(rst_n), .top_flags(top_flags), .top_valid(~empty),
      .block_mode(cfg_block_mode), .err_clr(err_clr), .lost(lost),
      .st_flags(st_flags), .overrun(overrun)
   );

   rxq_rts i_rts (
      .clk(clk), .rst_n(rst_n), .rts_en(cfg_rts_en), .host_bit(host_rts_bit),
      .full(full), .start_det(start_det), .rts_n(rts_n)
   );

   assign st_fe    = st_flags[FL_FRAME];
   assign st_pe    = st_flags[FL_PARITY];
   assign st_brk   = st_flags[FL_BREAK];
   assign rx_ready = ~empty;
   assign rx_full  = full;
endmodule

// File: rtl/rxq_flow_fifo_chk.sv
module rxq_flow_fifo_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              start_det,
   input logic              rd_en,
   input logic              err_clr,
   input logic              cfg_rts_en,
   input logic              cfg_block_mode,
   input logic              host_rts_bit,
   input logic [DATA_W-1:0] rd_data,
   input logic              st_fe,
   input logic              st_pe,
   input logic              st_brk,
   input logic              rx_ready,
   input logic              rx_full,
   input logic              overrun,
   input logic              rts_n
);
   a_r3_full_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> rx_ready);

   a_r4_lost_write_sets_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && wr_en) |=> overrun);

   a_r4_full_kept_without_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && wr_en && !rd_en) |=> rx_full);

   a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !err_clr) |=> overrun);

   a_r6_char_flags_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_block_mode && !rx_ready) |-> !(st_fe || st_pe || st_brk));

   a_r8_start_on_full_negates: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rts_en && host_rts_bit && rx_full && start_det && !rd_en) |=>
      (rts_n || !host_rts_bit || !cfg_rts_en));

   a_r9_not_full_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_full && host_rts_bit) |-> !rts_n);

   a_r10_host_bit_low_negates: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rts_bit |-> rts_n);

   a_r10_manual_follows_host: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rts_en |-> (rts_n == !host_rts_bit));

   a_r11_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_ready && rd_en && !wr_en) |=> ($stable(rd_data) && !rx_ready));
endmodule

bind rxq_flow_fifo rxq_flow_fifo_chk #(.DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .start_det(start_det),
   .rd_en(rd_en), .err_clr(err_clr), .cfg_rts_en(cfg_rts_en),
   .cfg_block_mode(cfg_block_mode), .host_rts_bit(host_rts_bit),
   .rd_data(rd_data), .st_fe(st_fe), .st_pe(st_pe), .st_brk(st_brk),
   .rx_ready(rx_ready), .rx_full(rx_full), .overrun(overrun), .rts_n(rts_n)
);

// File: tb/test_rxq_flow_fifo.sv
`timescale 1ns/1ps
module test_rxq_flow_fifo;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 0, wr_fe = 0, wr_pe = 0, wr_brk = 0;
   logic [DW-1:0] wr_data = '0;
   logic          start_det = 0, rd_en = 0, err_clr = 0;
   logic          cfg_rts_en = 0, cfg_block_mode = 0, cfg_deep = 0, host_rts_bit = 0;
   logic [DW-1:0] rd_data;
   logic          st_fe, st_pe, st_brk, rx_ready, rx_full, overrun, rts_n;

   int checks = 0;
   int failures = 0;

   // scoreboard: entry = {brk, pe, fe, data}
   logic [DW+2:0] exp_q[$];
   logic [DW-1:0] exp_last = '0;
   logic [2:0]    exp_acc = '0;
   logic          exp_ovr = 1'b0;

   always #2.5 clk = ~clk;

   rxq_flow_fifo i_rxq_flow_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_fe(wr_fe),
      .wr_pe(wr_pe), .wr_brk(wr_brk), .start_det(start_det), .rd_en(rd_en),
      .err_clr(err_clr), .cfg_rts_en(cfg_rts_en), .cfg_block_mode(cfg_block_mode),
      .cfg_deep(cfg_deep), .host_rts_bit(host_rts_bit), .rd_data(rd_data),
      .st_fe(st_fe), .st_pe(st_pe), .st_brk(st_brk), .rx_ready(rx_ready),
      .rx_full(rx_full), .overrun(overrun), .rts_n(rts_n)
   );

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int cap();
      return cfg_deep ? 16 : 8;
   endfunction

   function automatic logic [2:0] exp_flags();
      logic [2:0] cur;
      cur = (exp_q.size() != 0) ? exp_q[0][DW+2:DW] : 3'b000;
      return cfg_block_mode ? (exp_acc | cur) : cur;
   endfunction

   // driver: one character from the receiver, expectation queued
   task automatic drive_char(logic [DW-1:0] d, logic [2:0] f);
      @(negedge clk);
      wr_en = 1; wr_data = d; {wr_brk, wr_pe, wr_fe} = f;
      if (exp_q.size() < cap()) exp_q.push_back({f, d});
      else exp_ovr = 1'b1;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start_det = 1;
      @(negedge clk); start_det = 0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); err_clr = 1;
      exp_acc = '0; exp_ovr = 1'b0;
      @(negedge clk); err_clr = 0;
   endtask

   // monitor: compare head with scoreboard front, then remove it
   task automatic mon_pop(string req);
      logic [DW+2:0] e;
      e = exp_q[0];
      check(req, "head data", rd_data, e[DW-1:0]);
      check("R6/R7", "status flags", {st_brk, st_pe, st_fe}, exp_flags());
      @(negedge clk); rd_en = 1;
      exp_acc |= e[DW+2:DW];
      void'(exp_q.pop_front());
      exp_last = e[DW-1:0];
      @(negedge clk); rd_en = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1", "rx_ready", rx_ready, 0);
      check("R1", "rx_full", rx_full, 0);
      check("R1", "overrun", overrun, 0);
      check("R1", "flags", {st_brk, st_pe, st_fe}, 0);
      check("R1", "rd_data", rd_data, 0);
      check("R10", "rts_n host low", rts_n, 1);
      host_rts_bit = 1;
      @(negedge clk);
      check("R10", "rts_n host high", rts_n, 0);

      // depth 8, automatic throttling, per-character flags
      cfg_rts_en = 1;
      for (int i = 0; i < 8; i++) begin
         drive_char(DW'(8'h30 + i * 7), 3'(i));
         if (i == 6) check("R3", "full at 7 of 8", rx_full, 0);
      end
      check("R3", "full at 8", rx_full, 1);
      check("R3", "ready", rx_ready, 1);
      check("R8", "rts before start bit", rts_n, 0);
      pulse_start();
      check("R8", "rts after start bit on full", rts_n, 1);
      drive_char(8'hEE, 3'b111);
      check("R4", "overrun after lost char", overrun, exp_ovr);
      check("R8", "rts held while full", rts_n, 1);
      mon_pop("R2");
      check("R9", "rx_full after pop", rx_full, 0);
      check("R9", "rts released", rts_n, 0);
      while (exp_q.size() != 0) mon_pop("R2");
      check("R4", "lost char absent", rx_ready, 0);
      check("R5", "overrun sticky", overrun, 1);
      @(negedge clk); rd_en = 1;
      @(negedge clk); rd_en = 0;
      check("R11", "empty read ready", rx_ready, 0);
      check("R11", "empty read data", rd_data, exp_last);
      pulse_clr();
      check("R5", "overrun cleared", overrun, 0);

      // depth 16, throttling disabled
      cfg_deep = 1; cfg_rts_en = 0;
      for (int i = 0; i < 16; i++) begin
         drive_char(DW'(i * 13 + 5), 3'(7 - (i % 8)));
         if (i == 14) check("R3", "full at 15 of 16", rx_full, 0);
      end
      check("R3", "full at 16", rx_full, 1);
      pulse_start();
      check("R10", "no throttle when disabled", rts_n, 0);
      // write while full with a simultaneous read: still dropped
      @(negedge clk);
      wr_en = 1; wr_data = 8'hA5; rd_en = 1; exp_ovr = 1'b1;
      exp_last = exp_q[0][DW-1:0];
      void'(exp_q.pop_front());
      @(negedge clk); wr_en = 0; rd_en = 0;
      check("R4", "overrun with same-cycle read", overrun, 1);
      check("R4", "count after dropped write", rx_full, 0);
      while (exp_q.size() != 0) mon_pop("R2");
      host_rts_bit = 0;
      @(negedge clk);
      check("R10", "host bit low", rts_n, 1);
      host_rts_bit = 1;
      pulse_clr();

      // accumulated flags
      cfg_deep = 0; cfg_block_mode = 1;
      drive_char(8'h11, 3'b010);
      drive_char(8'h22, 3'b001);
      drive_char(8'h33, 3'b000);
      drive_char(8'h44, 3'b100);
      mon_pop("R7");
      mon_pop("R7");
      check("R7", "accumulated pe|fe", {st_brk, st_pe, st_fe}, 3'b011);
      pulse_clr();
      check("R7", "cleared accumulation", {st_brk, st_pe, st_fe}, 3'b000);
      mon_pop("R7");
      mon_pop("R7");
      check("R7", "held after drain", {st_brk, st_pe, st_fe}, 3'b100);
      cfg_block_mode = 0;
      @(negedge clk);
      check("R6", "char mode empty flags", {st_brk, st_pe, st_fe}, 3'b000);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule